// File: doc/BRIEF.md
# Frame Event Interrupt Unit

This block gathers the frame events of a multi-channel display fetch engine and turns them into one level-sensitive interrupt. Each event arrives as a one-cycle pulse carrying its kind (start of frame, end of frame, branch taken, input underrun, bus error), the channel that raised it, that channel's frame identifier and the two notification enables from the channel's current command word. Channel 0 events land in a primary status register. Events from the other channels land in a secondary status register. The primary register also records two controller events: quick disable and last frame done.

Two control registers hold the per-source mask bits. The main control register also holds the controller enable and a disable-on-frame-end request. Software clears status bits by writing ones. When a further unmasked event arrives while the interrupt line is already high, a sticky secondary-interrupt flag is set. Otherwise the event's frame identifier is captured into an identification register, so the first unmasked event of a burst can be found with a single read.

Top module: `frm_irq_unit`

## Requirements
- R1: `irq` is a register. It goes high one cycle after any unmasked source is present in the status registers or the masks, and it drops one cycle after the last one goes away. The primary sources and their mask bits in the main control register are: last frame done (status bit 0, mask bit 3), start of frame (bit 1, mask 4), underrun (bit 4, mask 5), quick disable (bit 7, mask 11), end of frame (bit 8, mask 6) and branch (bit 9, mask 20). Every secondary status bit is masked by the same bit of the channel control register. Bus error and the secondary-interrupt flag never drive the line.
- R2: Channel 0 events set primary bits: start of frame bit 1, end of frame bit 8, branch bit 9, underrun bit 4. An event from channel c ≥ 1 sets secondary bit c−1 (start), c+7 (end), c+15 (branch) or c+23 (underrun). Event kind codes are 0 start, 1 end, 2 branch, 3 underrun, 4 bus error.
- R3: A start-of-frame event is recorded only when its start enable is high, and an end-of-frame event only when its end enable is high. A gated-off event changes neither status, the identification register nor the line.
- R4: An event that records a bit whose mask is clear, or any bus error, sets primary bit 10 if `irq` is already high in that cycle. If `irq` is low, the event loads its frame identifier into `irq_id` instead. An event whose mask is set does neither.
- R5: A bus error on any valid channel sets primary bit 2 and ORs the channel number into primary bits 30:28, whatever the masks are.
- R6: Writing primary status (select 2) clears each of bits 11:0 whose data bit is 1. If data bit 2 is 1, it also clears bits 30:28. Writing secondary status (select 3) clears only the bits set in both the data and the clear mask 0x003E3F3F.
- R7: A write to the main control register (select 0) that takes bit 0 from 1 to 0 sets quick-disable status bit 7. Writing 0 over an already cleared bit 0 does not.
- R8: A frame-end pulse while main control bits 0 and 10 are both set clears bit 0 and sets last-frame-done status bit 0. Without bit 10, the pulse changes nothing.
- R9: When a status bit is set and cleared in the same cycle, the set wins.
- R10: Main control writes keep bits 26:0. Channel control writes (select 1) keep, for each channel c from 1 to NUM_CH−1, bits c−1, c+7, c+15 and c+23. Events that name a channel ≥ NUM_CH are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_valid | input | 1 | One-cycle event strobe |
| evt_kind | input | 3 | Event kind code |
| evt_chan | input | 3 | Channel raising the event |
| evt_fid | input | FID_W | Frame identifier of that channel |
| evt_sof_en | input | 1 | Start-of-frame notification enable from the command word |
| evt_eof_en | input | 1 | End-of-frame notification enable from the command word |
| frame_end | input | 1 | One-cycle end-of-frame pulse of the controller |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Write target: 0 main control, 1 channel control, 2 primary status, 3 secondary status |
| wr_data | input | 32 | Write data |
| ctrl_main | output | 32 | Main control register |
| ctrl_chan | output | 32 | Channel mask control register |
| stat_pri | output | 32 | Primary status register |
| stat_sec | output | 32 | Secondary status register |
| irq_id | output | FID_W | Captured frame identifier |
| irq | output | 1 | Registered interrupt line |

## Verification
The bench builds the unit with NUM_CH = 4 and FID_W = 8. This keeps channel 0 and three secondary channels, so every kind, channel and mask combination can be swept in a few cycles each. It also leaves channel codes 4 to 7 free in the 3-bit channel field, so the out-of-range drop can be tested. The sweep reaches secondary bits from every group, including bits that the secondary clear mask protects. The narrow identifier makes captured and uncaptured values easy to tell apart.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;

   localparam int unsigned REG_W = 32;
   localparam int unsigned CH_W  = 3;

   typedef enum logic [2:0] {
      EV_SOF      = 3'd0,
      EV_EOF      = 3'd1,
      EV_BRANCH   = 3'd2,
      EV_UNDERRUN = 3'd3,
      EV_BUSERR   = 3'd4
   } ev_kind_e;

   typedef enum logic [1:0] {
      RS_CTRL0 = 2'd0,
      RS_CTRL5 = 2'd1,
      RS_STAT0 = 2'd2,
      RS_STAT1 = 2'd3
   } reg_sel_e;

   // primary status bit positions
   localparam int unsigned P0_LDD  = 0;
   localparam int unsigned P0_SOF  = 1;
   localparam int unsigned P0_BERR = 2;
   localparam int unsigned P0_UNDR = 4;
   localparam int unsigned P0_QD   = 7;
   localparam int unsigned P0_EOF  = 8;
   localparam int unsigned P0_BS   = 9;
   localparam int unsigned P0_SINT = 10;
   localparam int unsigned BERR_CH_LO = 28;
   localparam int unsigned PRI_CLR_W  = 12;

   // main control bit positions
   localparam int unsigned C0_EN     = 0;
   localparam int unsigned C0_M_LDD  = 3;
   localparam int unsigned C0_M_SOF  = 4;
   localparam int unsigned C0_M_UNDR = 5;
   localparam int unsigned C0_M_EOF  = 6;
   localparam int unsigned C0_DISREQ = 10;
   localparam int unsigned C0_M_QD   = 11;
   localparam int unsigned C0_M_BS   = 20;
   localparam logic [REG_W-1:0] C0_WMASK = 32'h07FF_FFFF;

   // secondary group offsets relative to the channel number
   localparam int unsigned S_SOF_OFS  = 0;   // c - 1 + 1
   localparam int unsigned S_EOF_OFS  = 8;   // c + 7 + 1
   localparam int unsigned S_BS_OFS   = 16;  // c + 15 + 1
   localparam int unsigned S_UNDR_OFS = 24;  // c + 23 + 1

   function automatic logic [REG_W-1:0] chan_mask_bits(int unsigned n_ch);
      logic [REG_W-1:0] m;
      m = '0;
      for (int unsigned c = 1; c < n_ch; c++) begin
         m[c - 1 + S_SOF_OFS]  = 1'b1;
         m[c - 1 + S_EOF_OFS]  = 1'b1;
         m[c - 1 + S_BS_OFS]   = 1'b1;
         m[c - 1 + S_UNDR_OFS] = 1'b1;
      end
      return m;
   endfunction

endpackage

// File: rtl/frm_irq_ctrl.sv
module frm_irq_ctrl
   import frm_irq_pkg::*;
#(
   parameter logic [REG_W-1:0] C5_WMASK = 32'h3F3F_3F3F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   input  logic             frame_end,
   output logic [REG_W-1:0] ctrl0_q,
   output logic [REG_W-1:0] ctrl5_q,
   output logic             qd_pulse,
   output logic             ldd_pulse
);

   logic wr_c0;
   logic wr_c5;

   assign wr_c0 = wr_en && (reg_sel_e'(wr_sel) == RS_CTRL0);
   assign wr_c5 = wr_en && (reg_sel_e'(wr_sel) == RS_CTRL5);

   // enable taken away by software
   assign qd_pulse  = wr_c0 && ctrl0_q[C0_EN] && !wr_data[C0_EN];
   // frame ends while a stop was requested
   assign ldd_pulse = frame_end && ctrl0_q[C0_EN] && ctrl0_q[C0_DISREQ];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl0_q <= '0;
         ctrl5_q <= '0;
      end else begin
         if (wr_c0) begin
            ctrl0_q <= wr_data & C0_WMASK;
         end else if (ldd_pulse) begin
            ctrl0_q[C0_EN] <= 1'b0;
         end
         if (wr_c5) begin
            ctrl5_q <= wr_data & C5_WMASK;
         end
      end
   end

endmodule

// File: rtl/frm_irq_evmap.sv
module frm_irq_evmap
   import frm_irq_pkg::*;
#(
   parameter int unsigned NUM_CH = 7
) (
   input  logic             evt_valid,
   input  logic [2:0]       evt_kind,
   input  logic [CH_W-1:0]  evt_chan,
   input  logic             evt_sof_en,
   input  logic             evt_eof_en,
   input  logic [REG_W-1:0] ctrl0,
   input  logic [REG_W-1:0] ctrl5,
   output logic [REG_W-1:0] set0,
   output logic [REG_W-1:0] set1,
   output logic             notify
);

   ev_kind_e kind;
   logic     kind_rec;
   logic     chan_ok;
   logic     rec_ok;
   logic     berr_hit;

   logic [NUM_CH-1:0][REG_W-1:0] p_set_a;
   logic [NUM_CH-1:0][REG_W-1:0] s_set_a;
   logic [NUM_CH-1:0]            hit_a;
   logic [NUM_CH-1:0]            msk_a;

   assign kind    = ev_kind_e'(evt_kind);
   assign chan_ok = (32'(evt_chan) < NUM_CH);

   always_comb begin
      case (kind)
         EV_SOF:      kind_rec = evt_sof_en;
         EV_EOF:      kind_rec = evt_eof_en;
         EV_BRANCH,
         EV_UNDERRUN: kind_rec = 1'b1;
         default:     kind_rec = 1'b0;
      endcase
   end

   assign rec_ok   = evt_valid && chan_ok && kind_rec;
   assign berr_hit = evt_valid && chan_ok && (kind == EV_BUSERR);

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      logic [REG_W-1:0] ps;
      logic [REG_W-1:0] ss;
      logic             mk;

      assign hit_a[g] = rec_ok && (evt_chan == CH_W'(g));

      if (g == 0) begin : g_pri
         always_comb begin
            ps = '0;
            mk = 1'b1;
            if (hit_a[g]) begin
               case (kind)
                  EV_SOF:      begin ps[P0_SOF]  = 1'b1; mk = ctrl0[C0_M_SOF];  end
                  EV_EOF:      begin ps[P0_EOF]  = 1'b1; mk = ctrl0[C0_M_EOF];  end
                  EV_BRANCH:   begin ps[P0_BS]   = 1'b1; mk = ctrl0[C0_M_BS];   end
                  EV_UNDERRUN: begin ps[P0_UNDR] = 1'b1; mk = ctrl0[C0_M_UNDR]; end
                  default:     begin ps = '0; mk = 1'b1; end
               endcase
            end
         end
         assign ss = '0;
      end else begin : g_sec
         localparam int unsigned B_SOF  = g - 1 + S_SOF_OFS;
         localparam int unsigned B_EOF  = g - 1 + S_EOF_OFS;
         localparam int unsigned B_BS   = g - 1 + S_BS_OFS;
         localparam int unsigned B_UNDR = g - 1 + S_UNDR_OFS;
         always_comb begin
            ss = '0;
            mk = 1'b1;
            if (hit_a[g]) begin
               case (kind)
                  EV_SOF:      begin ss[B_SOF]  = 1'b1; mk = ctrl5[B_SOF];  end
                  EV_EOF:      begin ss[B_EOF]  = 1'b1; mk = ctrl5[B_EOF];  end
                  EV_BRANCH:   begin ss[B_BS]   = 1'b1; mk = ctrl5[B_BS];   end
                  EV_UNDERRUN: begin ss[B_UNDR] = 1'b1; mk = ctrl5[B_UNDR]; end
                  default:     begin ss = '0; mk = 1'b1; end
               endcase
            end
         end
         assign ps = '0;
      end

      assign p_set_a[g] = ps;
      assign s_set_a[g] = ss;
      assign msk_a[g]   = mk;
   end

   always_comb begin
      set0   = '0;
      set1   = '0;
      notify = berr_hit;
      for (int i = 0; i < int'(NUM_CH); i++) begin
         set0   = set0 | p_set_a[i];
         set1   = set1 | s_set_a[i];
         notify = notify | (hit_a[i] & ~msk_a[i]);
      end
      if (berr_hit) begin
         set0[P0_BERR] = 1'b1;
         set0[BERR_CH_LO +: CH_W] = evt_chan;
      end
   end

endmodule

// File: rtl/frm_irq_stat.sv
module frm_irq_stat
   import frm_irq_pkg::*;
#(
   parameter int unsigned      FID_W       = 32,
   parameter logic [REG_W-1:0] S1_CLR_MASK = 32'h003E_3F3F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] set0,
   input  logic [REG_W-1:0] set1,
   input  logic             notify,
   input  logic [FID_W-1:0] fid,
   input  logic             irq_now,
   input  logic             qd_pulse,
   input  logic             ldd_pulse,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [REG_W-1:0] wr_data,
   output logic [REG_W-1:0] stat0_q,
   output logic [REG_W-1:0] stat1_q,
   output logic [FID_W-1:0] id_q
);

   logic [REG_W-1:0] clr0;
   logic [REG_W-1:0] clr1;
   logic [REG_W-1:0] ev0;

   always_comb begin
      clr0 = '0;
      clr1 = '0;
      if (wr_en && (reg_sel_e'(wr_sel) == RS_STAT0)) begin
         clr0[PRI_CLR_W-1:0] = wr_data[PRI_CLR_W-1:0];
         if (wr_data[P0_BERR]) begin
            clr0[BERR_CH_LO +: CH_W] = '1;
         end
      end
      if (wr_en && (reg_sel_e'(wr_sel) == RS_STAT1)) begin
         clr1 = wr_data & S1_CLR_MASK;
      end
   end

   always_comb begin
      ev0          = set0;
      ev0[P0_QD]   = set0[P0_QD]   | qd_pulse;
      ev0[P0_LDD]  = set0[P0_LDD]  | ldd_pulse;
      ev0[P0_SINT] = set0[P0_SINT] | (notify & irq_now);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat0_q <= '0;
         stat1_q <= '0;
         id_q    <= '0;
      end else begin
         stat0_q <= (stat0_q & ~clr0) | ev0;
         stat1_q <= (stat1_q & ~clr1) | set1;
         if (notify && !irq_now) begin
            id_q <= fid;
         end
      end
   end

endmodule

// File: rtl/frm_irq_line.sv
module frm_irq_line
   import frm_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [REG_W-1:0] stat0,
   input  logic [REG_W-1:0] stat1,
   input  logic [REG_W-1:0] ctrl0,
   input  logic [REG_W-1:0] ctrl5,
   output logic             irq_q
);

   localparam int unsigned N_SRC = 6;
   localparam int unsigned SRC_BIT [N_SRC] = '{P0_LDD, P0_SOF, P0_UNDR, P0_QD, P0_EOF, P0_BS};
   localparam int unsigned MSK_BIT [N_SRC] = '{C0_M_LDD, C0_M_SOF, C0_M_UNDR, C0_M_QD, C0_M_EOF, C0_M_BS};

   logic [N_SRC-1:0] pri_req;
   logic             sec_req;

   for (genvar i = 0; i < N_SRC; i++) begin : g_src
      assign pri_req[i] = stat0[SRC_BIT[i]] & ~ctrl0[MSK_BIT[i]];
   end

   assign sec_req = |(stat1 & ~ctrl5);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_q <= 1'b0;
      end else begin
         irq_q <= (|pri_req) | sec_req;
      end
   end

endmodule

// File: rtl/frm_irq_unit.sv
module frm_irq_unit
   import frm_irq_pkg::*;
#(
   parameter int unsigned      NUM_CH      = 7,
   parameter int unsigned      FID_W       = 32,
   parameter logic [REG_W-1:0] S1_CLR_MASK = 32'h003E_3F3F
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             evt_valid,
   input  logic [2:0]       evt_kind,
   input  logic [2:0]       evt_chan,
   input  logic [FID_W-1:0] evt_fid,
   input  logic             evt_sof_en,
   input  logic             evt_eof_en,
   input  logic             frame_end,
   input  logic             wr_en,
   input  logic [1:0]       wr_sel,
   input  logic [31:0]      wr_data,
   output logic [31:0]      ctrl_main,
   output logic [31:0]      ctrl_chan,
   output logic [31:0]      stat_pri,
   output logic [31:0]      stat_sec,
   output logic [FID_W-1:0] irq_id,
   output logic             irq
);

   localparam logic [REG_W-1:0] C5_WMASK = chan_mask_bits(NUM_CH);

   if (NUM_CH < 1 || NUM_CH > 7) begin : g_bad_nch
      $error("frm_irq_unit: NUM_CH must lie in 1..7");
   end
   if (FID_W < 1 || FID_W > 32) begin : g_bad_fid
      $error("frm_irq_unit: FID_W must lie in 1..32");
   end

   logic [REG_W-1:0] set0;
   logic [REG_W-1:0] set1;
   logic             notify;
   logic             qd_pulse;
   logic             ldd_pulse;

   frm_irq_ctrl #(
      .C5_WMASK (C5_WMASK)
   ) u_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .frame_end (frame_end),
      .ctrl0_q   (ctrl_main),
      .ctrl5_q   (ctrl_chan),
      .qd_pulse  (qd_pulse),
      .ldd_pulse (ldd_pulse)
   );

   frm_irq_evmap #(
      .NUM_CH (NUM_CH)
   ) u_evmap (
      .evt_valid  (evt_valid),
      .evt_kind   (evt_kind),
      .evt_chan   (evt_chan),
      .evt_sof_en (evt_sof_en),
      .evt_eof_en (evt_eof_en),
      .ctrl0      (ctrl_main),
      .ctrl5      (ctrl_chan),
      .set0       (set0),
      .set1       (set1),
      .notify     (notify)
   );

   frm_irq_stat #(
      .FID_W       (FID_W),
      .S1_CLR_MASK (S1_CLR_MASK)
   ) u_stat (
      .clk       (clk),
      .rst_n     (rst_n),
      .set0      (set0),
      .set1      (set1),
      .notify    (notify),
      .fid       (evt_fid),
      .irq_now   (irq),
      .qd_pulse  (qd_pulse),
      .ldd_pulse (ldd_pulse),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data),
      .stat0_q   (stat_pri),
      .stat1_q   (stat_sec),
      .id_q      (irq_id)
   );

   frm_irq_line u_line (
      .clk   (clk),
      .rst_n (rst_n),
      .stat0 (stat_pri),
      .stat1 (stat_sec),
      .ctrl0 (ctrl_main),
      .ctrl5 (ctrl_chan),
      .irq_q (irq)
   );

endmodule

// File: rtl/frm_irq_unit_chk.sv
module frm_irq_unit_chk
   import frm_irq_pkg::*;
#(
   parameter logic [REG_W-1:0] S1_CLR_MASK = 32'h003E_3F3F
) (
   input logic        clk,
   input logic        rst_n,
   input logic        irq,
   input logic [31:0] stat_pri,
   input logic [31:0] stat_sec,
   input logic [31:0] ctrl_main
);

   AST_IRQ_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_pri == 32'h0 && stat_sec == 32'h0) |=> !irq); // R1

   AST_SINT_NEEDS_LINE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_pri[P0_SINT]) |-> $past(irq)); // R4

   AST_BERR_FIELD_PAIRED: assert property (@(posedge clk) disable iff (!rst_n)
      (stat_pri[BERR_CH_LO +: CH_W] != '0) |-> stat_pri[P0_BERR]); // R5

   AST_SEC_PROTECTED_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
      ((($past(stat_sec) & ~S1_CLR_MASK) & ~stat_sec) == 32'h0)); // R6

   AST_ENABLE_FALL_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ctrl_main[C0_EN]) |-> (stat_pri[P0_QD] || stat_pri[P0_LDD])); // R7

   AST_LDD_NEEDS_REQUEST: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(stat_pri[P0_LDD]) |-> $past(ctrl_main[C0_DISREQ])); // R8

endmodule

bind frm_irq_unit frm_irq_unit_chk #(
   .S1_CLR_MASK (S1_CLR_MASK)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq       (irq),
   .stat_pri  (stat_pri),
   .stat_sec  (stat_sec),
   .ctrl_main (ctrl_main)
);

// File: tb/frm_irq_unit_bench.sv
`timescale 1ns/1ps
module frm_irq_unit_bench;

   localparam int unsigned NCH = 4;
   localparam int unsigned FW  = 8;
   localparam logic [31:0] ALL_M0 = 32'h0010_0878;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          evt_valid = 1'b0;
   logic [2:0]    evt_kind = 3'd0;
   logic [2:0]    evt_chan = 3'd0;
   logic [FW-1:0] evt_fid = '0;
   logic          evt_sof_en = 1'b0;
   logic          evt_eof_en = 1'b0;
   logic          frame_end = 1'b0;
   logic          wr_en = 1'b0;
   logic [1:0]    wr_sel = 2'd0;
   logic [31:0]   wr_data = '0;
   logic [31:0]   ctrl_main, ctrl_chan, stat_pri, stat_sec;
   logic [FW-1:0] irq_id;
   logic          irq;

   int n_chk = 0;
   int n_err = 0;
   logic [31:0] e0, e1;
   logic [7:0]  f;
   int          p;

   always #4 clk = ~clk;

   frm_irq_unit #(.NUM_CH(NCH), .FID_W(FW)) u_frm_irq_unit (
      .clk(clk), .rst_n(rst_n), .evt_valid(evt_valid), .evt_kind(evt_kind),
      .evt_chan(evt_chan), .evt_fid(evt_fid), .evt_sof_en(evt_sof_en),
      .evt_eof_en(evt_eof_en), .frame_end(frame_end), .wr_en(wr_en),
      .wr_sel(wr_sel), .wr_data(wr_data), .ctrl_main(ctrl_main),
      .ctrl_chan(ctrl_chan), .stat_pri(stat_pri), .stat_sec(stat_sec),
      .irq_id(irq_id), .irq(irq));

   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst_n = 1'b0;
      tick();
      tick();
      rst_n = 1'b1;
      tick();
   endtask

   task automatic wr(input logic [1:0] s, input logic [31:0] d);
      wr_en = 1'b1; wr_sel = s; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic fire(input logic [2:0] k, input logic [2:0] c, input logic [7:0] fid,
                       input logic se, input logic ee);
      evt_valid = 1'b1; evt_kind = k; evt_chan = c; evt_fid = fid;
      evt_sof_en = se; evt_eof_en = ee;
      tick();
      evt_valid = 1'b0;
   endtask

   task automatic pulse_fe();
      frame_end = 1'b1;
      tick();
      frame_end = 1'b0;
   endtask

   function automatic int bitpos(input int k, input int c);
      if (c == 0) return (k == 0) ? 1 : (k == 1) ? 8 : (k == 2) ? 9 : 4;
      return (k == 0) ? c - 1 : (k == 1) ? c + 7 : (k == 2) ? c + 15 : c + 23;
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

   initial begin
      do_reset();
      chk("R1", "reset irq", 32'(irq), 32'h0);
      chk("R2", "reset primary", stat_pri, 32'h0);
      chk("R2", "reset secondary", stat_sec, 32'h0);
      chk("R4", "reset id", 32'(irq_id), 32'h0);

      // R2 / R1 / R4 sweep over channels, kinds and mask states
      for (int c = 0; c < int'(NCH); c++) begin
         for (int k = 0; k < 4; k++) begin
            for (int um = 0; um < 2; um++) begin
               do_reset();
               if (um == 0) begin
                  wr(2'd0, ALL_M0);
                  wr(2'd1, 32'hFFFF_FFFF);
               end
               f = 8'(16 * c + 4 * k + um + 1);
               p = bitpos(k, c);
               e0 = (c == 0) ? (32'h1 << p) : 32'h0;
               e1 = (c == 0) ? 32'h0 : (32'h1 << p);
               fire(3'(k), 3'(c), f, 1'b1, 1'b1);
               chk("R2", "sweep primary", stat_pri, e0);
               chk("R2", "sweep secondary", stat_sec, e1);
               chk("R4", "sweep id", 32'(irq_id), (um != 0) ? 32'(f) : 32'h0);
               chk("R1", "sweep irq before", 32'(irq), 32'h0);
               tick();
               chk("R1", "sweep irq after", 32'(irq), 32'(um));
               if (um != 0) begin
                  fire(3'(k), 3'(c), f ^ 8'hA5, 1'b1, 1'b1);
                  chk("R4", "second event sets flag", stat_pri, e0 | 32'h400);
                  chk("R4", "second event keeps id", 32'(irq_id), 32'(f));
               end
            end
         end
      end

      // R3 gating by command enables
      for (int c = 0; c < int'(NCH); c++) begin
         do_reset();
         fire(3'd0, 3'(c), 8'h5A, 1'b0, 1'b1);
         fire(3'd1, 3'(c), 8'h5B, 1'b1, 1'b0);
         tick();
         chk("R3", "gated primary", stat_pri, 32'h0);
         chk("R3", "gated secondary", stat_sec, 32'h0);
         chk("R3", "gated id", 32'(irq_id), 32'h0);
         chk("R3", "gated irq", 32'(irq), 32'h0);
      end

      // R10 out-of-range channels dropped
      do_reset();
      for (int c = int'(NCH); c < 8; c++) begin
         for (int k = 0; k < 5; k++) fire(3'(k), 3'(c), 8'h77, 1'b1, 1'b1);
      end
      tick();
      chk("R10", "far channel primary", stat_pri, 32'h0);
      chk("R10", "far channel secondary", stat_sec, 32'h0);
      chk("R10", "far channel id", 32'(irq_id), 32'h0);

      // R10 control write masks
      wr(2'd1, 32'hFFFF_FFFF);
      chk("R10", "channel ctrl mask", ctrl_chan, 32'h0707_0707);
      wr(2'd0, 32'hFFFF_FFFF);
      chk("R10", "main ctrl mask", ctrl_main, 32'h07FF_FFFF);
      chk("R7", "enable rise no flag", stat_pri, 32'h0);

      // R5 bus error per channel, masks all set
      for (int c = 0; c < int'(NCH); c++) begin
         do_reset();
         wr(2'd0, ALL_M0);
         wr(2'd1, 32'hFFFF_FFFF);
         fire(3'd4, 3'(c), 8'(8'h40 + c), 1'b0, 1'b0);
         chk("R5", "bus error status", stat_pri, 32'h4 | (32'(c) << 28));
         chk("R4", "bus error id", 32'(irq_id), 32'(8'h40 + c));
         tick();
         chk("R1", "bus error no line", 32'(irq), 32'h0);
         wr(2'd2, 32'h4);
         chk("R6", "bus error clear", stat_pri, 32'h0);
      end

      // R4 back-to-back capture, masked while high, bus error while high
      do_reset();
      fire(3'd0, 3'd1, 8'h11, 1'b1, 1'b1);
      fire(3'd1, 3'd2, 8'h22, 1'b1, 1'b1);
      chk("R4", "back-to-back id", 32'(irq_id), 32'h22);
      chk("R4", "back-to-back no flag", stat_pri, 32'h0);
      chk("R1", "back-to-back irq", 32'(irq), 32'h1);
      wr(2'd1, 32'h0000_0200);
      fire(3'd1, 3'd2, 8'h33, 1'b1, 1'b1);
      chk("R4", "masked while high no flag", stat_pri, 32'h0);
      chk("R4", "masked while high id", 32'(irq_id), 32'h22);
      fire(3'd4, 3'd3, 8'h44, 1'b0, 1'b0);
      chk("R5", "bus error while high", stat_pri, 32'h404 | (32'd3 << 28));
      chk("R4", "bus error while high id", 32'(irq_id), 32'h22);

      // R6 clears
      do_reset();
      fire(3'd0, 3'd0, 8'h01, 1'b1, 1'b1);
      fire(3'd1, 3'd0, 8'h02, 1'b1, 1'b1);
      fire(3'd2, 3'd0, 8'h03, 1'b1, 1'b1);
      chk("R2", "three primary", stat_pri, 32'h302 | 32'h400);
      wr(2'd2, 32'h0000_0100);
      chk("R6", "selective clear", stat_pri, 32'h602);
      fire(3'd0, 3'd1, 8'h04, 1'b1, 1'b1);
      fire(3'd2, 3'd1, 8'h05, 1'b1, 1'b1);
      fire(3'd2, 3'd2, 8'h06, 1'b1, 1'b1);
      chk("R2", "secondary set", stat_sec, 32'h0003_0001);
      wr(2'd3, 32'hFFFF_FFFF);
      chk("R6", "secondary clear mask", stat_sec, 32'h0001_0000);
      wr(2'd2, 32'hFFFF_FFFF);
      chk("R6", "primary full clear", stat_pri, 32'h0);

      // R9 set beats clear
      do_reset();
      fire(3'd0, 3'd0, 8'h09, 1'b1, 1'b1);
      evt_valid = 1'b1; evt_kind = 3'd0; evt_chan = 3'd0; evt_fid = 8'h0A;
      evt_sof_en = 1'b1; evt_eof_en = 1'b1;
      wr_en = 1'b1; wr_sel = 2'd2; wr_data = 32'h2;
      tick();
      evt_valid = 1'b0; wr_en = 1'b0;
      chk("R9", "set beats clear", stat_pri & 32'h2, 32'h2);
      wr(2'd2, 32'h2);
      chk("R9", "plain clear", stat_pri & 32'h2, 32'h0);

      // R7 quick disable
      do_reset();
      wr(2'd0, 32'h1);
      chk("R7", "enable on no flag", stat_pri, 32'h0);
      wr(2'd0, 32'h0);
      chk("R7", "disable flag", stat_pri, 32'h80);
      wr(2'd2, 32'h80);
      wr(2'd0, 32'h0);
      chk("R7", "zero over zero", stat_pri, 32'h0);

      // R8 last frame done
      do_reset();
      wr(2'd0, 32'h1);
      pulse_fe();
      chk("R8", "no request ctrl", ctrl_main, 32'h1);
      chk("R8", "no request status", stat_pri, 32'h0);
      wr(2'd0, 32'h409);
      pulse_fe();
      chk("R8", "request ctrl", ctrl_main, 32'h408);
      chk("R8", "request status", stat_pri, 32'h1);
      tick();
      chk("R1", "done masked", 32'(irq), 32'h0);
      wr(2'd0, 32'h0);
      chk("R1", "unmask latency", 32'(irq), 32'h0);
      tick();
      chk("R1", "unmasked line", 32'(irq), 32'h1);
      wr(2'd2, 32'h1);
      tick();
      chk("R1", "line drops", 32'(irq), 32'h0);

      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
   end

endmodule